// File: doc/BRIEF.md
# UART Interrupt Pending and Mask Unit

This unit collects the four interrupt causes of one UART channel into a source register. It masks them into a pending view and drives one level-sensitive interrupt line toward the system interrupt controller. The receive, error and modem causes arrive as single-cycle event pulses from the datapath around the block. The transmit cause has two origins: a pulse when a transmit write completes, and a threshold test on the transmit FIFO occupancy that is re-evaluated every cycle.

Software acknowledges causes by writing ones. A write of ones to the pending view clears the matching source bits. A write of ones to the source register clears them the same way. Software sets the mask with a plain register write. The threshold scale depends on the channel the instance is built for, so it is a parameter and not a register field. All pins are plain control and status. Nothing flows through the block, so no port needs a ready/valid handshake or back-pressure.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Cause bit positions are receive = bit 0, error = bit 1, transmit = bit 2 and modem = bit 3. A pulse on an event input sets its source bit on the next clock edge, and the bit stays set until it is cleared.
- R2: `rd_pend` always equals `rd_src` AND NOT `rd_mask`, in the same cycle.
- R3: `irq` is a register. After each clock edge it is high exactly when `rd_pend` was nonzero before that edge.
- R4: A write with `wr_sel` = 0 (pending acknowledge) clears every source bit whose `wr_data` bit is 1. Source bits with a 0 in `wr_data` keep their value.
- R5: A write with `wr_sel` = 1 (source acknowledge) clears every source bit whose `wr_data` bit is 1. Source bits with a 0 in `wr_data` keep their value.
- R6: A write with `wr_sel` = 2 loads `wr_data` into the mask on the next edge. `rd_pend` reflects the new mask in that same cycle.
- R7: While `fifo_en` is 1 and `tx_count` is at or below the trigger level, the transmit source bit is set on every edge. While `fifo_en` is 0, the count has no effect.
- R8: The trigger level is `tx_trig` times 32 for CHANNEL 0, times 8 for CHANNEL 1 and 4, and times 2 for CHANNEL 2 and 3. Any other channel gives a level of 0.
- R9: If an event and an acknowledge of the same bit fall in one cycle, the bit ends up set.
- R10: After reset, source, mask, pending and `irq` are all zero.
- R11: A write with `wr_sel` = 3 changes neither source nor mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_rx | input | 1 | Receive event pulse |
| ev_err | input | 1 | Error event pulse |
| ev_tx | input | 1 | Transmit write completed pulse |
| ev_modem | input | 1 | Modem event pulse |
| fifo_en | input | 1 | FIFO mode enable |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| tx_trig | input | TRIG_W | Transmit trigger field |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 pending ack, 1 source ack, 2 mask, 3 none |
| wr_data | input | 4 | Write data, one bit per cause |
| rd_src | output | 4 | Source register |
| rd_pend | output | 4 | Pending view |
| rd_mask | output | 4 | Mask register |
| irq | output | 1 | Interrupt line |

## Verification
Source and mask changes show up on `rd_src`, `rd_mask` and `rd_pend` one edge after the stimulus. `irq` follows one edge later again, so it lags an event or acknowledge by two edges. The bench drives inputs just after a falling edge. A behavioural model takes in the same inputs at each rising edge. Every output of two instances (CHANNEL 0 and CHANNEL 3) is compared with the model at the next falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NSRC = 4;

  localparam int SRC_RX    = 0;
  localparam int SRC_ERR   = 1;
  localparam int SRC_TX    = 2;
  localparam int SRC_MODEM = 3;

  typedef enum logic [1:0] {
    WSEL_PEND_ACK = 2'd0,
    WSEL_SRC_ACK  = 2'd1,
    WSEL_MASK     = 2'd2,
    WSEL_NONE     = 2'd3
  } wsel_e;

  typedef logic [NSRC-1:0] cause_t;

  // Trigger level as a plain number, used by checkers
  function automatic int unsigned chan_level(int ch, int unsigned trig);
    case (ch)
      0:       return trig * 32;
      1, 4:    return trig * 8;
      2, 3:    return trig * 2;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_tx_thresh.sv
module uart_irq_tx_thresh #(
  parameter int CHANNEL = 0,
  parameter int CNT_W   = 8,
  parameter int TRIG_W  = 3
) (
  input  logic              fifo_en,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [TRIG_W-1:0] tx_trig,
  output logic              tx_low
);
  localparam int LVL_W = TRIG_W + 5;
  localparam int CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W;

  logic [LVL_W-1:0] level;

  generate
    if (CHANNEL == 0) begin : g_x32
      assign level = LVL_W'(tx_trig) << 5;
    end else if (CHANNEL == 1 || CHANNEL == 4) begin : g_x8
      assign level = LVL_W'(tx_trig) << 3;
    end else if (CHANNEL == 2 || CHANNEL == 3) begin : g_x2
      assign level = LVL_W'(tx_trig) << 1;
    end else begin : g_none
      assign level = '0;
    end
  endgenerate

  assign tx_low = fifo_en && (CMP_W'(tx_count) <= CMP_W'(level));

endmodule

// File: rtl/uart_irq_src_bit.sv
module uart_irq_src_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  // a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/uart_irq_mask_out.sv
module uart_irq_mask_out
  import uart_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  cause_t src,
  input  logic   mask_wr,
  input  cause_t mask_data,
  output cause_t mask_q,
  output cause_t pend,
  output logic   irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= mask_data;
  end

  assign pend = src & ~mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pend;
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int CHANNEL = 0,
  parameter int CNT_W   = 8,
  parameter int TRIG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rx,
  input  logic              ev_err,
  input  logic              ev_tx,
  input  logic              ev_modem,
  input  logic              fifo_en,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [TRIG_W-1:0] tx_trig,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [3:0]        wr_data,
  output logic [3:0]        rd_src,
  output logic [3:0]        rd_pend,
  output logic [3:0]        rd_mask,
  output logic              irq
);
  wsel_e  sel;
  logic   tx_low;
  cause_t set_v;
  cause_t clr_v;
  cause_t src_q;
  logic   mask_wr;

  assign sel = wsel_e'(wr_sel);

  uart_irq_tx_thresh #(
    .CHANNEL(CHANNEL), .CNT_W(CNT_W), .TRIG_W(TRIG_W)
  ) u_thresh (
    .fifo_en (fifo_en),
    .tx_count(tx_count),
    .tx_trig (tx_trig),
    .tx_low  (tx_low)
  );

  always_comb begin
    set_v            = '0;
    set_v[SRC_RX]    = ev_rx;
    set_v[SRC_ERR]   = ev_err;
    set_v[SRC_TX]    = ev_tx | tx_low;
    set_v[SRC_MODEM] = ev_modem;
  end

  assign clr_v   = (wr_en && (sel == WSEL_PEND_ACK || sel == WSEL_SRC_ACK)) ? wr_data : '0;
  assign mask_wr = wr_en && (sel == WSEL_MASK);

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      uart_irq_src_bit u_bit (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (set_v[i]),
        .clr  (clr_v[i]),
        .q    (src_q[i])
      );
    end
  endgenerate

  uart_irq_mask_out u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (src_q),
    .mask_wr  (mask_wr),
    .mask_data(wr_data),
    .mask_q   (rd_mask),
    .pend     (rd_pend),
    .irq_q    (irq)
  );

  assign rd_src = src_q;

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk
  import uart_irq_pkg::*;
#(
  parameter int CHANNEL = 0,
  parameter int CNT_W   = 8,
  parameter int TRIG_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_rx,
  input logic              ev_err,
  input logic              ev_tx,
  input logic              ev_modem,
  input logic              fifo_en,
  input logic [CNT_W-1:0]  tx_count,
  input logic [TRIG_W-1:0] tx_trig,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [3:0]        wr_data,
  input logic [3:0]        rd_src,
  input logic [3:0]        rd_pend,
  input logic [3:0]        rd_mask,
  input logic              irq
);
  logic below;
  assign below = fifo_en && (int'(tx_count) <= int'(chan_level(CHANNEL, int'(tx_trig))));

  AST_RX_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx |=> rd_src[0]); // R1

  AST_PEND_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_pend & rd_mask) == 4'd0) && ((rd_pend & ~rd_src) == 4'd0)); // R2

  AST_IRQ_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend == 4'd0) |=> !irq); // R3

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && wr_data[3] && !ev_modem) |=> !rd_src[3]); // R4

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2) |=> (rd_mask == $past(wr_data))); // R6

  AST_TX_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    below |=> rd_src[2]); // R7

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_err && wr_en && wr_sel == 2'd1 && wr_data[1]) |=> rd_src[1]); // R9

  AST_NOP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3) |=> $stable(rd_mask)); // R11

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(
  .CHANNEL(CHANNEL), .CNT_W(CNT_W), .TRIG_W(TRIG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_rx(ev_rx), .ev_err(ev_err), .ev_tx(ev_tx),
  .ev_modem(ev_modem), .fifo_en(fifo_en), .tx_count(tx_count), .tx_trig(tx_trig),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_src(rd_src),
  .rd_pend(rd_pend), .rd_mask(rd_mask), .irq(irq)
);

// File: tb/test_uart_irq_ctrl.sv
`timescale 1ns/1ps
module test_uart_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_rx = 0, ev_err = 0, ev_tx = 0, ev_modem = 0, fifo_en = 0, wr_en = 0;
  logic [7:0] tx_count = 8'd255;
  logic [2:0] tx_trig = 3'd0;
  logic [1:0] wr_sel = 2'd3;
  logic [3:0] wr_data = 4'd0;
  logic [3:0] src0, pend0, mask0, src3, pend3, mask3;
  logic irq0, irq3;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string tag = "R10";

  always #4 clk = ~clk;

  uart_irq_ctrl #(.CHANNEL(0)) i_uart_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_rx(ev_rx), .ev_err(ev_err), .ev_tx(ev_tx),
    .ev_modem(ev_modem), .fifo_en(fifo_en), .tx_count(tx_count), .tx_trig(tx_trig),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_src(src0), .rd_pend(pend0), .rd_mask(mask0), .irq(irq0));

  uart_irq_ctrl #(.CHANNEL(3)) i_uart_irq_ctrl_ch3 (
    .clk(clk), .rst_n(rst_n), .ev_rx(ev_rx), .ev_err(ev_err), .ev_tx(ev_tx),
    .ev_modem(ev_modem), .fifo_en(fifo_en), .tx_count(tx_count), .tx_trig(tx_trig),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_src(src3), .rd_pend(pend3), .rd_mask(mask3), .irq(irq3));

  // behavioural reference, index 0 = channel 0, index 1 = channel 3
  int m_src[2], m_mask[2], m_irq[2];
  int scale[2] = '{32, 2};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        m_src[k] = 0; m_mask[k] = 0; m_irq[k] = 0;
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        int setb, clrb;
        m_irq[k] = ((m_src[k] & ~m_mask[k] & 15) != 0) ? 1 : 0;
        setb = int'(ev_rx) | (int'(ev_err) << 1) | (int'(ev_modem) << 3);
        if (ev_tx || (fifo_en && int'(tx_count) <= int'(tx_trig) * scale[k])) setb |= 4;
        clrb = (wr_en && wr_sel <= 2'd1) ? int'(wr_data) : 0;
        m_src[k] = ((m_src[k] & ~clrb) | setb) & 15;
        if (wr_en && wr_sel == 2'd2) m_mask[k] = int'(wr_data);
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cycles++;
    chk("src ch0",  int'(src0),  m_src[0]);
    chk("pend ch0 (R2)", int'(pend0), m_src[0] & ~m_mask[0] & 15);
    chk("mask ch0", int'(mask0), m_mask[0]);
    chk("irq ch0 (R3)",  int'(irq0),  m_irq[0]);
    chk("src ch3 (R8)",  int'(src3),  m_src[1]);
    chk("pend ch3", int'(pend3), m_src[1] & ~m_mask[1] & 15);
    chk("mask ch3", int'(mask3), m_mask[1]);
    chk("irq ch3",  int'(irq3),  m_irq[1]);
  endtask

  task automatic idle();
    ev_rx = 0; ev_err = 0; ev_tx = 0; ev_modem = 0; wr_en = 0; wr_sel = 2'd3; wr_data = 0;
  endtask

  task automatic wr(logic [1:0] s, logic [3:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    step();
    idle();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tag = "R10"; step(); step();
    chk("reset src R10", int'(src0), 0);
    chk("reset irq R10", int'(irq0), 0);
    rst_n = 1; step();

    tag = "R1";
    ev_rx = 1; step(); idle(); step(); step();
    ev_err = 1; step(); idle();
    ev_tx = 1; step(); idle();
    ev_modem = 1; step(); idle(); step(); step();
    chk("all sources R1", int'(src0), 15);

    tag = "R4"; wr(2'd0, 4'b0101); step(); step();
    chk("pending ack R4", int'(src0), 4'b1010);
    tag = "R5"; wr(2'd1, 4'b0010); step(); step();
    chk("source ack R5", int'(src0), 4'b1000);

    tag = "R6"; wr(2'd2, 4'b1000); step(); step();
    chk("masked pend R6", int'(pend0), 0);
    chk("masked irq R3", int'(irq0), 0);
    ev_rx = 1; step(); idle(); step(); step();
    wr(2'd2, 4'b0000); step(); step();

    tag = "R11"; wr(2'd3, 4'b1111); step();
    chk("no-op write R11", int'(src0), 4'b1001);

    tag = "R9";
    ev_rx = 1; wr_en = 1; wr_sel = 2'd0; wr_data = 4'b1111; step(); idle(); step();
    chk("event wins R9", int'(src0), 4'b0001);
    wr(2'd1, 4'b1111); step(); step();

    tag = "R7";
    fifo_en = 1; tx_trig = 3'd1; tx_count = 8'd2; step(); step();
    chk("below both R7", int'(src3), 4'b0100);
    tx_count = 8'd3; wr(2'd1, 4'b0100); step(); step();
    tag = "R8"; chk("ch3 above R8", int'(src3), 0);
    chk("ch0 below R8", int'(src0), 4'b0100);
    tx_count = 8'd32; step(); tx_count = 8'd33; wr(2'd1, 4'b0100); step(); step();
    chk("ch0 above R8", int'(src0), 0);
    tx_trig = 3'd0; tx_count = 8'd0; step(); step();
    tx_count = 8'd0; fifo_en = 0; wr(2'd1, 4'b0100); step(); step();
    tag = "R7"; chk("fifo off R7", int'(src0), 0);

    tag = "R1 R2 R3 R4 R5 R6 R7 R8 R9 R11";
    for (int n = 0; n < 400; n++) begin
      ev_rx = ($urandom % 8) == 0; ev_err = ($urandom % 8) == 0;
      ev_tx = ($urandom % 8) == 0; ev_modem = ($urandom % 8) == 0;
      fifo_en = $urandom % 2; tx_trig = 3'($urandom); tx_count = 8'($urandom);
      wr_en = $urandom % 2; wr_sel = 2'($urandom); wr_data = 4'($urandom);
      step();
    end
    idle(); step();
    finish_run();
  end
endmodule